// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave

This block is a receive-only I2C target that lets a host microcontroller load a bank of sixteen 8-bit control registers. These registers set up a video-processing datapath. SCL, SDA and the vertical-blanking level are brought into the system clock domain through two-flop synchronizers. Bus events are found by comparing each synchronized sample with the one before it. The block answers only to the 7-bit address 1000100, which is the byte 0x88 with the write bit. It pulls SDA low to acknowledge every byte it accepts.

After the address, the first byte selects a register. The next byte is written to that register. Register 15 is the control register:

- bit 0 enables auto-increment, so each further data byte goes to the next register.
- bit 1 selects deferred commit. In this mode, writes to registers 0 to 14 are staged in a shadow copy and reach the outputs only on the next rising edge of the vertical-blanking input.

Register 15 itself always takes effect at once, so both modes can be switched without waiting for a blanking interval.

Top module: `i2cw_ctl_slave`

## Requirements
- R1: An address byte of 0x88 (7-bit address 1000100, bit 0 = 0 for write) is acknowledged. The acknowledge is a low level on the SDA pull output during the ninth SCL pulse.
- R2: An address byte that differs from 0x88, including 0x89 with bit 0 = 1 (read), is not acknowledged. Every later byte up to the next START is also not acknowledged and writes nothing.
- R3: The SDA pull output changes only after an SCL falling edge or a bus condition. It asserts after the falling edge that ends the eighth bit of an accepted byte, and it is released after the falling edge that ends the ninth pulse.
- R4: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bytes clocked while the bus is idle are not acknowledged. A transfer that ends after the subaddress byte writes nothing.
- R5: The first data byte after a subaddress is acknowledged and written to the register that the subaddress selects.
- R6: With auto-increment off (register 15 bit 0 = 0), a data byte after the first one in the same transfer is not acknowledged and is not written.
- R7: With auto-increment on, each further data byte is acknowledged and written to the next register index.
- R8: A subaddress of 16 or more is not acknowledged. A data byte whose target index would pass 15 during auto-increment is not acknowledged and not written.
- R9: A repeated START abandons the current transfer and restarts address matching. A register selected before the repeated START is not written.
- R10: With deferred commit on (register 15 bit 1 = 1), a write to registers 0 to 14 leaves the outputs unchanged. The value appears on the output on the next rising edge of the vertical-blanking input.
- R11: A write to register 15 takes effect at once in both commit modes. Its bits 0 and 1 govern all later data bytes.
- R12: After reset every register reads 0, and the SDA pull output is low-inactive (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| vblank_in | input | 1 | Vertical-blanking level; its rising edge commits staged writes |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| regs_o | output | 128 | Active register values; register i is bits [8i+7:8i] |

## Verification
The main function is tried with four kinds of transfer:

- A three-byte transfer with auto-increment off. Then a longer burst with auto-increment off, which separates the single-write rule from the burst rule.
- A burst with auto-increment on that runs into register 15. This shows that the index advances and that it stops at the bank edge.
- Wrong-address and read-bit transfers, plus bytes clocked without a START. These show that only a proper write address opens a transfer.
- A transfer broken by a repeated START, and writes made in deferred mode before and after a blanking edge. These separate abandonment from completion, and immediate commit from staged commit.

// File: rtl/i2cw_pkg.sv
// Shared types for the write-only I2C control register slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2cw_pkg;

    // Byte-level receive phases of one bus transfer.
    typedef enum logic [2:0] {
        ST_IDLE,   // bus free, waiting for START
        ST_ADDR,   // shifting the address byte
        ST_SUB,    // shifting the register index byte
        ST_DATA,   // shifting data bytes
        ST_SKIP    // transfer rejected, wait for START or STOP
    } rx_state_t;

endpackage

// File: rtl/i2cw_sync.sv
// Multi-bit two-or-more flop synchronizer with a chosen reset value.
// Assumes: each bit is an independent slow level (no bus coherency needed).
module i2cw_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2cw_rx.sv
// Bit and byte engine: finds START/STOP, shifts bytes on SCL rising edges,
// decides acknowledges and issues one register write per accepted data byte.
// Assumes: scl/sda are already synchronized; SCL is slow against clk.
module i2cw_rx
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000100,
    parameter int         NREG     = 16,
    localparam int        AW       = $clog2(NREG),
    localparam int        PW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl,
    input  logic          sda,
    input  logic          auto_inc,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_pull
);

    logic         scl_q, sda_q;
    logic         scl_rise, scl_fall, start_c, stop_c;
    rx_state_t    state, nstate;
    logic [7:0]   shreg;
    logic [3:0]   bit_cnt;
    logic         ack_ph;
    logic         first;
    logic [PW-1:0] ptr;
    logic         take;
    logic         decide;

    // Previous samples for edge and bus-condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign start_c  = scl & scl_q & sda_q & ~sda;
    assign stop_c   = scl & scl_q & ~sda_q & sda;
    assign decide   = scl_fall && (bit_cnt == 4'd8) && !ack_ph;

    // Acknowledge decision and next phase for the byte just shifted in.
    always_comb begin
        take   = 1'b0;
        nstate = state;
        unique case (state)
            ST_ADDR: begin
                if (shreg == {DEV_ADDR, 1'b0}) begin
                    take   = 1'b1;
                    nstate = ST_SUB;
                end
            end
            ST_SUB: begin
                if (shreg < 8'(NREG)) begin
                    take   = 1'b1;
                    nstate = ST_DATA;
                end
            end
            ST_DATA: begin
                take = (first || auto_inc) && (ptr < PW'(NREG));
            end
            default: ;
        endcase
    end

    // Transfer sequencing, shifting, acknowledge drive and write issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            first    <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                ack_ph   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                ack_ph   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (state != ST_IDLE && state != ST_SKIP) begin
                if (scl_rise && !ack_ph && bit_cnt != 4'd8) begin
                    shreg   <= {shreg[6:0], sda};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (scl_fall && ack_ph) begin
                    ack_ph   <= 1'b0;
                    sda_pull <= 1'b0;
                    bit_cnt  <= '0;
                    if (!sda_pull) state <= ST_SKIP;
                end else if (decide) begin
                    ack_ph   <= 1'b1;
                    sda_pull <= take;
                    state    <= nstate;
                    if (state == ST_SUB) begin
                        ptr   <= shreg[PW-1:0];
                        first <= 1'b1;
                    end
                    if (state == ST_DATA && take) begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr[AW-1:0];
                        wr_data <= shreg;
                        ptr     <= ptr + PW'(1);
                        first   <= 1'b0;
                    end
                end
            end
        end
    end

    AST_ACK_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_c && !stop_c) |=> $stable(sda_pull)); // R3

    AST_READ_BIT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && state == ST_ADDR && shreg[0] && !start_c && !stop_c) |=> !sda_pull); // R2

    AST_SINGLE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && state == ST_DATA && !first && !auto_inc && !start_c && !stop_c)
        |=> (!sda_pull && !wr_en)); // R6

endmodule

// File: rtl/i2cw_bank.sv
// Register bank with active and shadow copies. The last index is the
// control register (bit 0 auto-increment, bit 1 deferred commit), which is
// always written at once. Staged values commit on a vertical-blanking rise.
// Assumes: vblank is already synchronized.
module i2cw_bank #(
    parameter int  NREG = 16,
    localparam int AW   = $clog2(NREG),
    localparam int CTRL = NREG - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            vblank,
    output logic            auto_inc,
    output logic [NREG*8-1:0] regs_o
);

    logic [7:0]      act [NREG];
    logic [7:0]      shd [NREG];
    logic [NREG-1:0] pend;
    logic            vb_q;
    logic            vb_rise;
    logic            defer;

    assign vb_rise  = vblank & ~vb_q;
    assign defer    = act[CTRL][1];
    assign auto_inc = act[CTRL][0];

    // Commit staged values on blanking, then apply this cycle's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q <= 1'b0;
            pend <= '0;
            for (int i = 0; i < NREG; i++) begin
                act[i] <= '0;
                shd[i] <= '0;
            end
        end else begin
            vb_q <= vblank;
            if (vb_rise) begin
                for (int i = 0; i < NREG; i++) begin
                    if (pend[i]) act[i] <= shd[i];
                end
                pend <= '0;
            end
            if (wr_en) begin
                shd[wr_addr] <= wr_data;
                if (defer && int'(wr_addr) != CTRL) pend[wr_addr] <= 1'b1;
                else                                 act[wr_addr] <= wr_data;
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g*8 +: 8] = act[g];
    end

    AST_DEFER_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && defer && int'(wr_addr) != CTRL && !vb_rise) |=> $stable(regs_o)); // R10

    AST_CTRL_APPLIES_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == CTRL) |=> (act[CTRL] == $past(wr_data))); // R11

endmodule

// File: rtl/i2cw_ctl_slave.sv
// Top of the write-only I2C control register slave: synchronizes the pads,
// runs the receive engine and holds the register bank.
// Assumes: SCL period spans many clk cycles; no clock stretching or reads.
module i2cw_ctl_slave #(
    parameter logic [6:0] DEV_ADDR = 7'b1000100,
    parameter int         NREG     = 16,
    localparam int        AW       = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               vblank_in,
    output logic               sda_pull_o,
    output logic [NREG*8-1:0]  regs_o
);

    logic [2:0]    pads_s;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          auto_inc;

    i2cw_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vblank_in, sda_in, scl_in}),
        .q     (pads_s)
    );

    i2cw_rx #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (pads_s[0]),
        .sda      (pads_s[1]),
        .auto_inc (auto_inc),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_pull (sda_pull_o)
    );

    i2cw_bank #(.NREG(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .vblank   (pads_s[2]),
        .auto_inc (auto_inc),
        .regs_o   (regs_o)
    );

endmodule

// File: tb/sim_i2cw_ctl_slave.sv
`timescale 1ns/1ps
module sim_i2cw_ctl_slave;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_h = 1'b1;
    logic         sda_h = 1'b1;
    logic         vblank = 1'b0;
    logic         sda_pull_o;
    logic [127:0] regs_o;
    logic         sda_line;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R12";

    // Behavioural reference state: active, shadow, pending.
    logic [7:0] m_act [16];
    logic [7:0] m_shd [16];
    bit         m_pend [16];

    always #2.5 clk = ~clk;

    assign sda_line = sda_h & ~sda_pull_o;

    i2cw_ctl_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_h),
        .sda_in     (sda_line),
        .vblank_in  (vblank),
        .sda_pull_o (sda_pull_o),
        .regs_o     (regs_o)
    );

    function automatic logic [127:0] model_flat();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_act[i];
        return v;
    endfunction

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    // Register outputs compared with the model on every clock while settled.
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (regs_o !== model_flat()) begin
                errors++;
                $display("FAIL %s registers: got %0h expected %0h", cur_req, regs_o, model_flat());
            end
        end
    end

    task automatic wait_q();
        repeat (10) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic i2c_stop();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wait_q();
            scl_h = 1'b1; wait_q(); wait_q();
            scl_h = 1'b0; wait_q();
        end
        sda_h = 1'b1; wait_q();
        chk({req, " ack slot"}, {127'd0, sda_pull_o}, {127'd0, exp_ack});
        scl_h = 1'b1; wait_q();
        chk({req, " ack during ninth pulse"}, {127'd0, ~sda_line}, {127'd0, exp_ack});
        wait_q();
        scl_h = 1'b0; wait_q();
        chk("R3 release after ninth fall", {127'd0, sda_pull_o}, 128'd0);
    endtask

    task automatic mwrite(input int a, input logic [7:0] d);
        if (a == 15 || !m_act[15][1]) begin
            m_act[a] = d;
            m_shd[a] = d;
        end else begin
            m_shd[a]  = d;
            m_pend[a] = 1'b1;
        end
    endtask

    // One transfer: the model predicts each acknowledge and write.
    task automatic xfer(input logic [7:0] bs[$], input bit do_stop, input string req);
        bit dead;
        bit first;
        int ptr;
        bit e;
        cmp_en = 1'b0;
        cur_req = req;
        i2c_start();
        dead = 1'b0; first = 1'b0; ptr = 0;
        foreach (bs[k]) begin
            e = 1'b0;
            if (!dead) begin
                if (k == 0) e = (bs[k] == 8'h88);
                else if (k == 1) begin
                    e = (bs[k] < 8'd16);
                    ptr = int'(bs[k]);
                    first = 1'b1;
                end else begin
                    e = (first || m_act[15][0]) && ptr < 16;
                    if (e) begin
                        mwrite(ptr, bs[k]);
                        ptr++;
                        first = 1'b0;
                    end
                end
                if (!e) dead = 1'b1;
            end
            send_byte(bs[k], e, req);
        end
        if (do_stop) begin
            i2c_stop();
            repeat (6) @(negedge clk);
            cmp_en = 1'b1;
        end
    endtask

    task automatic blank_pulse();
        cmp_en = 1'b0;
        vblank = 1'b1;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (m_pend[i]) m_act[i] = m_shd[i];
            m_pend[i] = 1'b0;
        end
        vblank = 1'b0;
        repeat (6) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_act[i] = '0; m_shd[i] = '0; m_pend[i] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12: reset state
        chk("R12 registers after reset", regs_o, 128'd0);
        chk("R12 pull released after reset", {127'd0, sda_pull_o}, 128'd0);
        cmp_en = 1'b1;

        // R1 R5: plain three-byte write
        xfer('{8'h88, 8'h02, 8'h5A}, 1'b1, "R5");
        chk("R5 reg2 written", {120'd0, regs_o[23:16]}, 128'h5A);

        // R2: wrong address, then read bit set
        xfer('{8'h8A, 8'h03, 8'h11}, 1'b1, "R2");
        xfer('{8'h89, 8'h03, 8'h22}, 1'b1, "R2");
        chk("R2 reg3 untouched", {120'd0, regs_o[31:24]}, 128'd0);

        // R6: extra bytes without auto-increment
        xfer('{8'h88, 8'h04, 8'hA1, 8'hA2, 8'hA3}, 1'b1, "R6");
        chk("R6 reg5 untouched", {120'd0, regs_o[47:40]}, 128'd0);

        // R4: subaddress only, then bytes clocked while idle
        xfer('{8'h88, 8'h05}, 1'b1, "R4");
        cmp_en = 1'b0;
        send_byte(8'h88, 1'b0, "R4 idle");
        send_byte(8'h06, 1'b0, "R4 idle");
        repeat (4) @(negedge clk);
        cmp_en = 1'b1;
        chk("R4 reg5 untouched", {120'd0, regs_o[47:40]}, 128'd0);

        // R11 R7 R8: enable auto-increment, burst into the bank edge
        xfer('{8'h88, 8'h0F, 8'h01}, 1'b1, "R11");
        xfer('{8'h88, 8'h03, 8'h31, 8'h32, 8'h33, 8'h34}, 1'b1, "R7");
        chk("R7 reg6 written", {120'd0, regs_o[55:48]}, 128'h34);
        xfer('{8'h88, 8'h0D, 8'hD0, 8'hE0, 8'h01, 8'h77}, 1'b1, "R8");
        xfer('{8'h88, 8'h10, 8'h99}, 1'b1, "R8");
        chk("R8 reg0 untouched", {120'd0, regs_o[7:0]}, 128'd0);

        // R9: repeated START abandons the first index
        xfer('{8'h88, 8'h07}, 1'b0, "R9");
        xfer('{8'h88, 8'h08, 8'h33}, 1'b1, "R9");
        chk("R9 reg8 written", {120'd0, regs_o[71:64]}, 128'h33);
        chk("R9 reg7 untouched", {120'd0, regs_o[63:56]}, 128'd0);

        // R10 R11: deferred commit through a blanking edge
        xfer('{8'h88, 8'h0F, 8'h02}, 1'b1, "R11");
        chk("R11 control applied at once", {120'd0, regs_o[127:120]}, 128'h02);
        xfer('{8'h88, 8'h01, 8'hC3}, 1'b1, "R10");
        chk("R10 reg1 held before blanking", {120'd0, regs_o[15:8]}, 128'd0);
        blank_pulse();
        chk("R10 reg1 after blanking", {120'd0, regs_o[15:8]}, 128'hC3);
        repeat (20) @(negedge clk);

        done = 1'b1;
        cmp_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule